// File: doc/BRIEF.md
# Address-Sequence Nonvolatile Command Detector

This block watches the access cycles that reach a small memory and looks for a fixed, ordered run of six read addresses. The run is a request to copy the volatile contents into nonvolatile storage, or to copy them back. Each access arrives as a 13-bit address together with an active-low chip select and an active-low write enable. A one-clock strobe marks each access as valid.

The first five addresses of the run are always 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order. The sixth address picks the command: 0x0F0F asks for a save and 0x0F0E asks for a restore. Only selected read cycles move the matcher. A selected write cycle anywhere in the run cancels it. A selected read at the wrong address also cancels it, except that an address of 0x0000 starts a new attempt at once. When the run completes, a one-clock request pulse goes to a downstream controller, which carries out the transfer.

Top module: `nv_seq_detect`

## Requirements
- R1: A synchronous active-high `rst` returns the matcher to idle with both request outputs low. A run that was partly entered before reset does not complete after it.
- R2: Selected read accesses to 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F raise `store_req` in the clock cycle after the sixth strobe.
- R3: The same five leading addresses followed by 0x0F0E raise `recall_req` in the clock cycle after the sixth strobe.
- R4: Any other order of addresses, a missing step, or any other sixth address raises no request.
- R5: A strobed access with chip select low and `acc_we_n` low (a write) aborts the run at any step, so the remaining steps alone raise no request.
- R6: A strobed access with `acc_ce_n` high (deselected) leaves the match progress unchanged and raises no request.
- R7: Cycles with `acc_valid` low are ignored, whatever their address, select and write values.
- R8: A selected read that does not match the expected step but has address 0x0000 counts as step one of a new run.
- R9: Each request lasts exactly one clock. After it the matcher is idle, so repeating the sixth address alone raises no further request.
- R10: `store_req` and `recall_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | One-clock strobe that qualifies an access |
| acc_addr | input | 13 | Access address |
| acc_ce_n | input | 1 | Chip select, active low |
| acc_we_n | input | 1 | Write enable, active low (high means read) |
| store_req | output | 1 | One-clock request for a nonvolatile save |
| recall_req | output | 1 | One-clock request for a nonvolatile restore |

## Verification
The two complete runs show that the sixth address alone decides between the two pulses. Runs with two addresses swapped, or with a wrong last address, show that matching is exact and ordered. Runs with deselected cycles or unstrobed junk placed between steps separate "ignored" from "abort": the first kind must still complete, while a write or a reset placed in the middle must not. A run that restarts on 0x0000, and a lone sixth address sent after a completed command, show how the matcher recovers and that it returns to idle after firing.

// File: rtl/nv_seq_detect.sv
module nv_seq_detect #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] SEQ_A0 = 13'h0000,
  parameter logic [ADDR_W-1:0] SEQ_A1 = 13'h1555,
  parameter logic [ADDR_W-1:0] SEQ_A2 = 13'h0AAA,
  parameter logic [ADDR_W-1:0] SEQ_A3 = 13'h1FFF,
  parameter logic [ADDR_W-1:0] SEQ_A4 = 13'h10F0,
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ce_n,
  input  logic              acc_we_n,
  output logic              store_req,
  output logic              recall_req
);
  localparam int STEPS  = 6;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] want;

  always_comb begin
    case (step)
      STEP_W'(1): want = SEQ_A1;
      STEP_W'(2): want = SEQ_A2;
      STEP_W'(3): want = SEQ_A3;
      STEP_W'(4): want = SEQ_A4;
      default:    want = SEQ_A0;
    endcase
  end

  wire live       = acc_valid & ~acc_ce_n;
  wire rd         = live & acc_we_n;
  wire at_last    = (step == LAST);
  wire hit_mid    = rd & ~at_last & (acc_addr == want);
  wire hit_store  = rd & at_last & (acc_addr == STORE_ADDR);
  wire hit_recall = rd & at_last & (acc_addr == RECALL_ADDR);
  wire restart    = rd & (acc_addr == SEQ_A0);

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= hit_store;
      recall_req <= hit_recall;
      if (live) begin
        if (hit_mid)      step <= step + STEP_W'(1);
        else if (restart) step <= STEP_W'(1);
        else              step <= '0;
      end
    end
  end
endmodule

module nv_seq_detect_chk #(
  parameter int ADDR_W = 13,
  parameter int STEP_W = 3,
  parameter logic [ADDR_W-1:0] SEQ_A0 = 13'h0000,
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_ce_n,
  input logic              acc_we_n,
  input logic [STEP_W-1:0] step,
  input logic              store_req,
  input logic              recall_req
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(store_req && recall_req));

  p_store_src_r2: assert property (@(posedge clk) disable iff (rst)
    store_req |-> $past(acc_valid && !acc_ce_n && acc_we_n && acc_addr == STORE_ADDR));

  p_recall_src_r3: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> $past(acc_valid && !acc_ce_n && acc_we_n && acc_addr == RECALL_ADDR));

  p_write_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_ce_n && !acc_we_n) |=> (step == '0 && !store_req && !recall_req));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || acc_ce_n) |=> ($stable(step) && !store_req && !recall_req));

  p_zero_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_ce_n && acc_we_n && acc_addr == SEQ_A0) |=> (step == STEP_W'(1)));

  p_store_once_r9: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);

  p_recall_once_r9: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);

  p_idle_after_r9: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |-> (step == '0));
endmodule

bind nv_seq_detect nv_seq_detect_chk #(
  .ADDR_W(ADDR_W), .STEP_W(STEP_W), .SEQ_A0(SEQ_A0),
  .STORE_ADDR(STORE_ADDR), .RECALL_ADDR(RECALL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_ce_n(acc_ce_n), .acc_we_n(acc_we_n), .step(step),
  .store_req(store_req), .recall_req(recall_req)
);

// File: tb/nv_seq_detect_test.sv
module nv_seq_detect_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [12:0] acc_addr = '0;
  logic acc_ce_n = 1'b1;
  logic acc_we_n = 1'b1;
  logic store_req, recall_req;
  int total = 0;
  int bad = 0;

  typedef struct { int code; string req; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  nv_seq_detect uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_ce_n(acc_ce_n), .acc_we_n(acc_we_n),
    .store_req(store_req), .recall_req(recall_req)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic drive(input logic v, input logic ce_n, input logic we_n,
                       input logic [12:0] a, input int code, input string req);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_ce_n = ce_n; acc_we_n = we_n; acc_addr = a;
    e.code = code; e.req = req;
    q.push_back(e);
  endtask

  task automatic rd(input logic [12:0] a, input int code, input string req);
    drive(1'b1, 1'b0, 1'b1, a, code, req);
  endtask

  task automatic lead5(input string req);
    rd(13'h0000, 0, req); rd(13'h1555, 0, req); rd(13'h0AAA, 0, req);
    rd(13'h1FFF, 0, req); rd(13'h10F0, 0, req);
  endtask

  task automatic quiet(input string req);
    drive(1'b0, 1'b1, 1'b1, 13'h0, 0, req);
  endtask

  initial begin : monitor
    exp_t e;
    int got;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        got = (store_req && recall_req) ? 3 : recall_req ? 2 : store_req ? 1 : 0;
        total++;
        if (got !== e.code) begin
          bad++;
          $display("FAIL %s: request code got=%0d expected=%0d (0 none,1 store,2 recall)",
                   e.req, got, e.code);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish got=hung expected=done");
    summary();
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2;
    total++;
    if (store_req !== 1'b0 || recall_req !== 1'b0) begin
      bad++;
      $display("FAIL R1: after reset got=%b%b expected=00", store_req, recall_req);
    end

    // R2 store run, then R9 single pulse
    lead5("R2"); rd(13'h0F0F, 1, "R2"); quiet("R9");
    // R3 recall run
    lead5("R3"); rd(13'h0F0E, 2, "R3"); quiet("R9");
    // R4 swapped order
    rd(13'h0000, 0, "R4"); rd(13'h0AAA, 0, "R4"); rd(13'h1555, 0, "R4");
    rd(13'h1FFF, 0, "R4"); rd(13'h10F0, 0, "R4"); rd(13'h0F0F, 0, "R4");
    // R4 wrong last address
    lead5("R4"); rd(13'h0F0D, 0, "R4");
    // R5 write in the middle
    rd(13'h0000, 0, "R5"); rd(13'h1555, 0, "R5"); rd(13'h0AAA, 0, "R5");
    drive(1'b1, 1'b0, 1'b0, 13'h1FFF, 0, "R5");
    rd(13'h10F0, 0, "R5"); rd(13'h0F0F, 0, "R5");
    // R5 write as the last step
    lead5("R5"); drive(1'b1, 1'b0, 1'b0, 13'h0F0F, 0, "R5"); rd(13'h0F0F, 0, "R5");
    // R6 deselected junk between steps
    rd(13'h0000, 0, "R6"); drive(1'b1, 1'b1, 1'b1, 13'h0123, 0, "R6");
    rd(13'h1555, 0, "R6"); drive(1'b1, 1'b1, 1'b0, 13'h1555, 0, "R6");
    rd(13'h0AAA, 0, "R6"); rd(13'h1FFF, 0, "R6");
    drive(1'b1, 1'b1, 1'b1, 13'h0000, 0, "R6");
    rd(13'h10F0, 0, "R6"); drive(1'b1, 1'b1, 1'b1, 13'h0F0F, 0, "R6");
    rd(13'h0F0F, 1, "R6");
    // R7 unstrobed junk between steps
    rd(13'h0000, 0, "R7"); drive(1'b0, 1'b0, 1'b0, 13'h0777, 0, "R7");
    rd(13'h1555, 0, "R7"); rd(13'h0AAA, 0, "R7");
    drive(1'b0, 1'b0, 1'b1, 13'h0000, 0, "R7");
    rd(13'h1FFF, 0, "R7"); rd(13'h10F0, 0, "R7");
    drive(1'b0, 1'b0, 1'b1, 13'h0F0F, 0, "R7");
    rd(13'h0F0E, 2, "R7");
    // R8 restart on 0x0000
    rd(13'h0000, 0, "R8"); rd(13'h1555, 0, "R8");
    rd(13'h0000, 0, "R8"); rd(13'h1555, 0, "R8"); rd(13'h0AAA, 0, "R8");
    rd(13'h1FFF, 0, "R8"); rd(13'h10F0, 0, "R8"); rd(13'h0F0F, 1, "R8");
    // R9 lone last address after a completed run
    rd(13'h0F0F, 0, "R9"); rd(13'h10F0, 0, "R9"); rd(13'h0F0E, 0, "R9");
    // R1 reset mid-run
    lead5("R1");
    @(negedge clk); rst = 1'b1; acc_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    rd(13'h0F0F, 0, "R1");
    // R10 both kinds back to back, never together
    lead5("R10"); rd(13'h0F0E, 2, "R10");
    lead5("R10"); rd(13'h0F0F, 1, "R10"); quiet("R10");

    quiet("R9"); quiet("R9");
    wait (q.size() == 0);
    @(posedge clk); #3;
    summary();
    $finish;
  end
endmodule